// File: doc/BRIEF.md
# Quad Color Pack and Masked Write

This block takes the four float RGBA results of a 2x2 pixel quad and converts every channel to an 8-bit unsigned-normalized byte. It packs each pixel into a 32-bit word in one of two selectable channel orders. It then merges the four packed words with the quad already held in the framebuffer, under a per-pixel alive mask. The pixel coordinates give the byte offset of the quad inside a 32x32 tile, where each quad is stored as one 16-byte unit.

The caller presents one quad per request with `in_valid`. One clock later the block returns the 128-bit quad to store, its tile offset and a store strobe. If the format code is one the block does not support, the strobe stays low and an error flag is raised instead.

Top module: `quad_color_pack`

## Requirements
- R1: Each channel converts as floor(c*256), saturated to 255. Any value at or above 1.0, including +infinity, gives 255. A set sign bit, a denormal or a NaN gives 0. The conversion decodes the IEEE-754 single exponent and mantissa directly.
- R2: Format code 0 packs a pixel word as A<<24 | R<<16 | G<<8 | B. For example A=0xAA, R=0x11, G=0x44, B=0x77 gives 0xAA114477.
- R3: Format code 1 packs a pixel word as B<<24 | G<<16 | R<<8 | A.
- R4: Pixel i occupies bits [32i+31:32i] of every 128-bit color input, of `fb_quad` and of `st_quad`, and it is governed by `alive[i]`. A pixel whose alive bit is 1 takes its new packed word. A pixel whose alive bit is 0 keeps its `fb_quad` word.
- R5: `st_offset` equals (((y>>1)<<4) + (x>>1)) << 4 for tile-local coordinates x and y in 0..31.
- R6: A request with `in_valid` high and a supported format produces `st_quad`, `st_offset` and a one-cycle `st_valid` pulse on the next clock.
- R7: Format codes 2 and 3 are unsupported. For such a request, on the next clock `st_valid` stays low, `fmt_err` pulses high for one cycle, and `st_quad` equals `fb_quad` with all four words kept.
- R8: While `rst_n` is low at a clock edge, every output is cleared to zero.
- R9: In a cycle with `in_valid` low, `st_quad` and `st_offset` hold their values, and `st_valid` and `fmt_err` are low on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe for one quad |
| pix_x | input | 5 | Tile-local pixel column |
| pix_y | input | 5 | Tile-local pixel row |
| fmt_sel | input | 2 | Packing format code (0, 1 supported) |
| alive | input | 4 | Per-pixel alive mask |
| frag_r | input | 128 | Red, four float32 lanes |
| frag_g | input | 128 | Green, four float32 lanes |
| frag_b | input | 128 | Blue, four float32 lanes |
| frag_a | input | 128 | Alpha, four float32 lanes |
| fb_quad | input | 128 | Current framebuffer quad |
| st_quad | output | 128 | Quad to store |
| st_offset | output | 12 | Quad byte offset inside the tile |
| st_valid | output | 1 | Store strobe |
| fmt_err | output | 1 | Unsupported-format pulse |

## Verification
The bench builds the block with its default parameters: 8-bit channels and a 32-pixel tile. At that size all 1024 coordinate pairs can be swept exhaustively against the offset formula. The conversion exponent window is also narrow enough that every edge of it can be hit: just under 1/256, exactly 1/256, just under 1.0, 1.0, infinity, NaN, a denormal and negative values. The two packing orders and several alive patterns are checked with byte values chosen so that each lane and each channel is distinct.

// File: rtl/qpk_pkg.sv
// Shared constants and helpers for the quad color pack block.
// Assumes IEEE-754 single-precision inputs and four channels per pixel.
package qpk_pkg;
    localparam int FP_W     = 32;
    localparam int FP_EXP_W = 8;
    localparam int FP_MAN_W = 23;
    localparam int FP_BIAS  = 127;
    localparam int NCH      = 4;   // channel index: 0=R 1=G 2=B 3=A
    localparam int LANES    = 4;   // 2x2 quad

    typedef enum logic [1:0] {
        FMT_ARGB = 2'd0,
        FMT_BGRA = 2'd1
    } pack_fmt_e;

    // True for the format codes the packer implements.
    function automatic logic fmt_known(input logic [1:0] code);
        return (code == FMT_ARGB) || (code == FMT_BGRA);
    endfunction
endpackage

// File: rtl/qpk_unorm_cvt.sv
// Converts one float32 to an unsigned-normalized integer of CH_W bits,
// equal to floor(c * 2^CH_W) saturated to all ones.
// Assumes CH_W <= 16. Negative values, denormals and NaN give zero.
module qpk_unorm_cvt
    import qpk_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic [FP_W-1:0] f_in,
    output logic [CH_W-1:0] u_out
);
    localparam int LO_EXP = FP_BIAS - CH_W;

    logic                sgn;
    logic [FP_EXP_W-1:0] ex;
    logic [FP_MAN_W-1:0] man;
    logic [FP_MAN_W:0]   sig;
    logic [FP_EXP_W-1:0] sh;
    logic [CH_W-1:0]     scaled;

    assign {sgn, ex, man} = f_in;
    assign sig    = {1'b1, man};
    assign sh     = ex - FP_EXP_W'(LO_EXP);
    assign scaled = CH_W'(sig >> (FP_EXP_W'(FP_MAN_W) - sh));

    // Select the saturated, zero or shifted result from the exponent range.
    always_comb begin
        if (ex == '1 && man != '0) begin
            u_out = '0;
        end else if (sgn) begin
            u_out = '0;
        end else if (ex >= FP_EXP_W'(FP_BIAS)) begin
            u_out = '1;
        end else if (ex < FP_EXP_W'(LO_EXP)) begin
            u_out = '0;
        end else begin
            u_out = scaled;
        end
    end
endmodule

// File: rtl/qpk_pixel_pack.sv
// Packs four CH_W-bit channels (R lowest, then G, B, A) into one pixel
// word in the selected channel order. Unknown codes give an all-zero word.
module qpk_pixel_pack
    import qpk_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic [NCH*CH_W-1:0] chans,
    input  logic [1:0]          fmt,
    output logic [NCH*CH_W-1:0] word
);
    logic [CH_W-1:0] r, g, b, a;

    assign r = chans[0*CH_W +: CH_W];
    assign g = chans[1*CH_W +: CH_W];
    assign b = chans[2*CH_W +: CH_W];
    assign a = chans[3*CH_W +: CH_W];

    // Place each channel into its byte slot for the chosen order.
    always_comb begin
        case (fmt)
            FMT_ARGB: word = {a, r, g, b};
            FMT_BGRA: word = {b, g, r, a};
            default:  word = '0;
        endcase
    end
endmodule

// File: rtl/qpk_tile_offset.sv
// Byte offset of a 2x2 quad in a square tile stored quad by quad.
// Assumes TILE_W and QUAD_BYTES are powers of two. The pixel LSBs are
// dropped by the caller.
module qpk_tile_offset #(
    parameter int TILE_W     = 32,
    parameter int QUAD_BYTES = 16,
    localparam int QC_W      = $clog2(TILE_W) - 1,
    localparam int QB_LOG    = $clog2(QUAD_BYTES),
    localparam int OFF_W     = 2 * QC_W + QB_LOG
) (
    input  logic [QC_W-1:0]  qx,
    input  logic [QC_W-1:0]  qy,
    output logic [OFF_W-1:0] offset
);
    // Row-major quad index times quad size, built by concatenation.
    assign offset = {qy, qx, {QB_LOG{1'b0}}};
endmodule

// File: rtl/quad_color_pack.sv
// Converts, packs and mask-merges one 2x2 quad of float colors and
// computes its byte offset in the tile. There is one register stage.
// Assumes tile-local coordinates and a TILE_W that is a power of two.
module quad_color_pack
    import qpk_pkg::*;
#(
    parameter int CH_W   = 8,
    parameter int TILE_W = 32,
    localparam int PIX_W      = NCH * CH_W,
    localparam int QUAD_W     = LANES * PIX_W,
    localparam int CLR_W      = LANES * FP_W,
    localparam int COORD_W    = $clog2(TILE_W),
    localparam int QUAD_BYTES = QUAD_W / 8,
    localparam int OFF_W      = 2 * (COORD_W - 1) + $clog2(QUAD_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [1:0]        fmt_sel,
    input  logic [LANES-1:0]  alive,
    input  logic [CLR_W-1:0]  frag_r,
    input  logic [CLR_W-1:0]  frag_g,
    input  logic [CLR_W-1:0]  frag_b,
    input  logic [CLR_W-1:0]  frag_a,
    input  logic [QUAD_W-1:0] fb_quad,
    output logic [QUAD_W-1:0] st_quad,
    output logic [OFF_W-1:0]  st_offset,
    output logic              st_valid,
    output logic              fmt_err
);
    logic [CLR_W-1:0]  chan_in [NCH];
    logic [QUAD_W-1:0] merged;
    logic [OFF_W-1:0]  offset_c;
    logic              fmt_ok;
    logic              unused_lsb;

    assign chan_in[0] = frag_r;
    assign chan_in[1] = frag_g;
    assign chan_in[2] = frag_b;
    assign chan_in[3] = frag_a;
    assign fmt_ok     = fmt_known(fmt_sel);
    assign unused_lsb = pix_x[0] ^ pix_y[0];

    // One converter set and one packer per pixel lane.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [PIX_W-1:0] bytes_l;
        logic [PIX_W-1:0] word_l;

        for (genvar c = 0; c < NCH; c++) begin : g_chan
            qpk_unorm_cvt #(.CH_W(CH_W)) i_cvt (
                .f_in (chan_in[c][l*FP_W +: FP_W]),
                .u_out(bytes_l[c*CH_W +: CH_W])
            );
        end

        qpk_pixel_pack #(.CH_W(CH_W)) i_pack (
            .chans(bytes_l),
            .fmt  (fmt_sel),
            .word (word_l)
        );

        // A live pixel takes the new word, a dead one keeps the old word.
        assign merged[l*PIX_W +: PIX_W] = alive[l] ? word_l : fb_quad[l*PIX_W +: PIX_W];
    end

    qpk_tile_offset #(.TILE_W(TILE_W), .QUAD_BYTES(QUAD_BYTES)) i_off (
        .qx    (pix_x[COORD_W-1:1]),
        .qy    (pix_y[COORD_W-1:1]),
        .offset(offset_c)
    );

    // Register the result and the strobes for one request per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_quad   <= '0;
            st_offset <= '0;
            st_valid  <= 1'b0;
            fmt_err   <= 1'b0;
        end else begin
            st_valid <= in_valid & fmt_ok;
            fmt_err  <= in_valid & ~fmt_ok;
            if (in_valid) begin
                st_quad   <= fmt_ok ? merged : fb_quad;
                st_offset <= offset_c;
            end
        end
    end
endmodule

// File: rtl/qpk_checker.sv
// Temporal properties of quad_color_pack, attached with bind.
module qpk_checker #(
    parameter int QUAD_W = 128,
    parameter int OFF_W  = 12,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        fmt_sel,
    input logic [LANES-1:0]  alive,
    input logic [QUAD_W-1:0] fb_quad,
    input logic [QUAD_W-1:0] st_quad,
    input logic [OFF_W-1:0]  st_offset,
    input logic              st_valid,
    input logic              fmt_err
);
    a_r6_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt_sel < 2'd2) |=> (st_valid && !fmt_err));

    a_r7_bad_fmt: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt_sel >= 2'd2) |=> (fmt_err && !st_valid && st_quad == $past(fb_quad)));

    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_valid && fmt_err));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(st_quad) && $stable(st_offset) && !st_valid && !fmt_err));

    a_r4_all_dead: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && alive == '0) |=> st_quad == $past(fb_quad));
endmodule

bind quad_color_pack qpk_checker #(
    .QUAD_W(QUAD_W), .OFF_W(OFF_W), .LANES(qpk_pkg::LANES)
) i_qpk_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_sel(fmt_sel),
    .alive(alive), .fb_quad(fb_quad), .st_quad(st_quad),
    .st_offset(st_offset), .st_valid(st_valid), .fmt_err(fmt_err)
);

// File: tb/test_quad_color_pack.sv
module test_quad_color_pack;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [4:0]   pix_x = '0, pix_y = '0;
    logic [1:0]   fmt_sel = '0;
    logic [3:0]   alive = '0;
    logic [127:0] frag_r = '0, frag_g = '0, frag_b = '0, frag_a = '0, fb_quad = '0;
    logic [127:0] st_quad;
    logic [11:0]  st_offset;
    logic         st_valid, fmt_err;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    quad_color_pack i_quad_color_pack (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pix_x(pix_x), .pix_y(pix_y),
        .fmt_sel(fmt_sel), .alive(alive), .frag_r(frag_r), .frag_g(frag_g),
        .frag_b(frag_b), .frag_a(frag_a), .fb_quad(fb_quad), .st_quad(st_quad),
        .st_offset(st_offset), .st_valid(st_valid), .fmt_err(fmt_err)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Exact float32 for byte/256, which converts back to that byte.
    function automatic logic [31:0] f_of(input logic [7:0] b);
        int p = 7;
        logic [31:0] m;
        if (b == 8'd0) return 32'h0;
        while (!b[p]) p--;
        m = 32'(b) << (23 - p);
        return {1'b0, 8'(119 + p), m[22:0]};
    endfunction

    // Issue one request and return at the negedge after its capture edge.
    task automatic send(input logic [4:0] x, input logic [4:0] y, input logic [1:0] f,
                        input logic [3:0] al);
        @(negedge clk);
        pix_x = x; pix_y = y; fmt_sel = f; alive = al; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Per-lane bytes for the pack tests; lane 0 carries the worked example.
    logic [7:0] lr [4] = '{8'h11, 8'h21, 8'h31, 8'hFF};
    logic [7:0] lg [4] = '{8'h44, 8'h52, 8'h00, 8'h80};
    logic [7:0] lb [4] = '{8'h77, 8'h63, 8'h9C, 8'h01};
    logic [7:0] la [4] = '{8'hAA, 8'h74, 8'hC5, 8'h7F};

    task automatic load_lanes();
        for (int l = 0; l < 4; l++) begin
            frag_r[l*32 +: 32] = f_of(lr[l]);
            frag_g[l*32 +: 32] = f_of(lg[l]);
            frag_b[l*32 +: 32] = f_of(lb[l]);
            frag_a[l*32 +: 32] = f_of(la[l]);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 st_quad", st_quad, '0);
        chk("R8 st_offset", 128'(st_offset), '0);
        chk("R8 st_valid", 128'(st_valid), '0);
        chk("R8 fmt_err", 128'(fmt_err), '0);
        rst_n = 1'b1;
    endtask

    task automatic t_convert();
        logic [31:0] fv [14] = '{32'h3F800000, 32'h40000000, 32'h7F800000, 32'h7FC00000,
                                 32'hBF000000, 32'h00000000, 32'h3F000000, 32'h3E800000,
                                 32'h3F7FFFFF, 32'h3B800000, 32'h3B7FFFFF, 32'h3DCCCCCD,
                                 32'h00000001, 32'hFF800000};
        logic [7:0]  ev [14] = '{8'd255, 8'd255, 8'd255, 8'd0, 8'd0, 8'd0, 8'd128, 8'd64,
                                 8'd255, 8'd1, 8'd0, 8'd25, 8'd0, 8'd0};
        fb_quad = {4{32'h5A5A5A5A}};
        for (int i = 0; i < 14; i++) begin
            frag_r = {4{fv[i]}}; frag_g = frag_r; frag_b = frag_r; frag_a = frag_r;
            send(5'd0, 5'd0, 2'd0, 4'hF);
            chk($sformatf("R1 convert %h", fv[i]), st_quad, {16{ev[i]}});
        end
    endtask

    task automatic t_argb();
        logic [127:0] exp;
        load_lanes();
        for (int l = 0; l < 4; l++) exp[l*32 +: 32] = {la[l], lr[l], lg[l], lb[l]};
        send(5'd2, 5'd3, 2'd0, 4'hF);
        chk("R2 argb quad", st_quad, exp);
        chk("R2 argb example lane0", 128'(st_quad[31:0]), 128'h0AA114477 & 128'hFFFFFFFF);
        chk("R6 argb strobe", 128'(st_valid), 128'd1);
        @(negedge clk);
        chk("R6 strobe one cycle", 128'(st_valid), 128'd0);
    endtask

    task automatic t_bgra();
        logic [127:0] exp;
        load_lanes();
        for (int l = 0; l < 4; l++) exp[l*32 +: 32] = {lb[l], lg[l], lr[l], la[l]};
        send(5'd7, 5'd1, 2'd1, 4'hF);
        chk("R3 bgra quad", st_quad, exp);
        chk("R6 bgra strobe", 128'(st_valid), 128'd1);
        chk("R6 bgra no err", 128'(fmt_err), 128'd0);
    endtask

    task automatic t_mask();
        logic [3:0] pats [6] = '{4'b0000, 4'b0101, 4'b1010, 4'b0001, 4'b1000, 4'b1111};
        logic [127:0] exp;
        load_lanes();
        fb_quad = 128'hDEADBEEF_CAFEF00D_01234567_89ABCDEF;
        foreach (pats[i]) begin
            for (int l = 0; l < 4; l++)
                exp[l*32 +: 32] = pats[i][l] ? {la[l], lr[l], lg[l], lb[l]} : fb_quad[l*32 +: 32];
            send(5'd4, 5'd4, 2'd0, pats[i]);
            chk($sformatf("R4 alive=%b", pats[i]), st_quad, exp);
        end
    endtask

    task automatic t_offset();
        for (int y = 0; y < 32; y++)
            for (int x = 0; x < 32; x++) begin
                send(5'(x), 5'(y), 2'd0, 4'hF);
                chk($sformatf("R5 offset x=%0d y=%0d", x, y), 128'(st_offset),
                    128'((((y >> 1) << 4) + (x >> 1)) << 4));
            end
    endtask

    task automatic t_bad_fmt();
        load_lanes();
        fb_quad = 128'h0F0E0D0C_0B0A0908_07060504_03020100;
        for (int f = 2; f < 4; f++) begin
            send(5'd9, 5'd9, 2'(f), 4'hF);
            chk($sformatf("R7 fmt %0d strobe", f), 128'(st_valid), 128'd0);
            chk($sformatf("R7 fmt %0d err", f), 128'(fmt_err), 128'd1);
            chk($sformatf("R7 fmt %0d quad", f), st_quad, fb_quad);
            @(negedge clk);
            chk($sformatf("R7 fmt %0d err one cycle", f), 128'(fmt_err), 128'd0);
        end
    endtask

    task automatic t_hold();
        logic [127:0] q;
        logic [11:0]  o;
        load_lanes();
        send(5'd31, 5'd30, 2'd0, 4'hF);
        q = st_quad; o = st_offset;
        pix_x = 5'd0; pix_y = 5'd0; fmt_sel = 2'd1; alive = 4'h0; fb_quad = '1;
        repeat (2) @(negedge clk);
        chk("R9 hold quad", st_quad, q);
        chk("R9 hold offset", 128'(st_offset), 128'(o));
        chk("R9 idle strobe", 128'(st_valid), 128'd0);
        chk("R9 idle err", 128'(fmt_err), 128'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_convert();
        t_argb();
        t_bgra();
        t_mask();
        t_bad_fmt();
        t_hold();
        t_offset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule